// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Controller

This block is a register-programmed SPI engine that works either as the clock-driving master or as a clocked slave. Software sets the clock idle level, the sampling phase, the bit order and a transfer length between 8 and 16 bits in a control register. It writes a word into the data register and then waits for the completion flag or the interrupt line. Each transfer is full duplex. The outgoing word leaves on the data-out pin while the incoming word is assembled from the data-in pin, and the received word is then read back from the same data register.

In master mode the block creates SCK from a clock-count register and never runs faster than one eighth of its input clock. In slave mode it passes the external SCK, data and select lines through a short synchronizer and follows SCK edges only while the active-low select is held low. A status register holds a completion flag and a write-collision flag. Both flags are cleared by reading the status register and then accessing the data register. The interrupt output is the enabled OR of the two flags.

Top module: `spi_duplex_ctrl`

## Requirements
- R1: After reset the control register reads 0 (slave mode, 8-bit), the clock-count register reads 8, the status register reads 0, `irq` is low and `sck_out` is low.
- R2: Register map by `reg_sel`: 0 control, 1 status, 2 data, 3 clock count. Control bit 2 enables variable length. When bit 2 is 0 a transfer is 8 bits. When bit 2 is 1, field 11:8 gives the length: codes 8 to 15 select that many bits, 0 selects 16, and 1 to 7 select 8.
- R3: Control bit 4 is the SCK idle level. `sck_out` sits at that level whenever the master is not transferring, and it returns there after every transfer.
- R4: Control bit 3 selects the phase. With 0, data is sampled on the first SCK edge of each bit and changed on the second. With 1, data is changed on the first edge and sampled on the second.
- R5: Control bit 6 selects the order. With 0, bit L-1 of an L-bit word goes first. With 1, bit 0 goes first.
- R6: Control bit 5 selects master (1) or slave (0). In a transfer between a master and a slave, each side receives the other's word, right-aligned, with unused high bits zero.
- R7: Each SCK half period in master mode lasts P/2 input clocks. P is the clock-count value, but values below 8 act as 8 and odd values round down to even.
- R8: A data write during a transfer is ignored: the word on the wire does not change. The write sets the collision flag, which is status bit 1.
- R9: Status bit 0 sets when a transfer completes. Both flags clear only on a data-register access that follows a status read. A data access without that earlier status read leaves them set.
- R10: `irq` is high exactly when control bit 7 is set and at least one status flag is set.
- R11: In slave mode, SCK edges while `ss_n_in` is high are ignored. No bits are counted and no completion occurs, and the next selected transfer starts from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read arms flag clearing) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| sck_out | output | 1 | Master serial clock |
| mosi_out | output | 1 | Master serial data out |
| miso_in | input | 1 | Master serial data in |
| sck_in | input | 1 | Slave serial clock |
| mosi_in | input | 1 | Slave serial data in |
| miso_out | output | 1 | Slave serial data out |
| ss_n_in | input | 1 | Slave select, active low |

## Verification
A master instance and a slave instance exchange words across all eight combinations of idle level, phase and bit order, and at every length from 8 to 16. The bench records the bits at the sampling edges it derives itself. This shows whether the sampling edge, the bit order and the length decode are each correct on their own, which a loopback match alone would not reveal. A sweep of clock-count values, including values below the minimum and odd values, separates the clamping from the rounding. Directed sequences cover a collision write in mid-transfer, a data read without a prior status read, and SCK toggling while the slave is deselected.

// File: rtl/spi_duplex_pkg.sv
package spi_duplex_pkg;

    localparam int DW = 16;
    localparam int LW = $clog2(DW + 1);
    localparam int IW = $clog2(DW);
    localparam int MIN_BITS = 8;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
    localparam logic [1:0] SEL_RATE = 2'd3;

    typedef struct packed {
        logic [3:0] width_code;
        logic       irq_en;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic       width_en;
    } ctrl_t;

    typedef struct packed {
        logic [LW-1:0] cnt;
        logic [DW-1:0] tx;
        logic [DW-1:0] rx;
    } eng_state_t;

    function automatic logic [LW-1:0] width_of(input ctrl_t c);
        logic [LW-1:0] w;
        if (!c.width_en)              w = LW'(MIN_BITS);
        else if (c.width_code == 4'd0) w = LW'(DW);
        else if (c.width_code[3])     w = LW'(c.width_code);
        else                          w = LW'(MIN_BITS);
        return w;
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] r_d, r_q;
        if (g == 0) begin : g_head
            always_comb r_d = d;
        end else begin : g_tail
            always_comb r_d = g_stage[g-1].r_q;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= RST_VAL;
            else        r_q <= r_d;
        end
    end

    assign q = g_stage[STAGES-1].r_q;

endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider #(
    parameter int CW   = 8,
    parameter int MINP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] period,
    output logic          tick
);

    localparam logic [CW-1:0] MIN_VAL = CW'(MINP);

    logic [CW-1:0] eff, half, cnt_d, cnt_q;

    always_comb begin
        eff   = (period < MIN_VAL) ? MIN_VAL : period;
        half  = eff >> 1;
        tick  = run && (cnt_q == half - 1'b1);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
    import spi_duplex_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_word,
    input  logic          clr,
    input  logic          lead,
    input  logic          trail,
    input  logic          din,
    input  logic [LW-1:0] len,
    input  logic          cpha,
    input  logic          lsbf,
    output logic          dout,
    output logic          finish,
    output logic [DW-1:0] rx_word
);

    eng_state_t s_d, s_q;
    logic [LW-1:0] cur;
    logic [IW-1:0] bidx;

    always_comb begin
        s_d    = s_q;
        finish = 1'b0;
        // bit position on the wire: phase 1 advances the count on the lead edge
        if (cpha) cur = (s_q.cnt == '0) ? '0 : s_q.cnt - 1'b1;
        else      cur = s_q.cnt;
        if (cur >= len) cur = len - 1'b1;
        bidx = lsbf ? cur[IW-1:0] : IW'(len - 1'b1 - cur);
        dout = s_q.tx[bidx];

        if (load) begin
            s_d.tx  = load_word;
            s_d.rx  = '0;
            s_d.cnt = '0;
        end else if (clr) begin
            s_d.cnt = '0;
        end else if (!cpha) begin
            if (lead && s_q.cnt < len) s_d.rx[bidx] = din;
            if (trail && s_q.cnt < len) begin
                s_d.cnt = s_q.cnt + 1'b1;
                finish  = (s_q.cnt + 1'b1 == len);
            end
        end else begin
            if (lead && s_q.cnt < len) s_d.cnt = s_q.cnt + 1'b1;
            if (trail && s_q.cnt != '0) begin
                s_d.rx[bidx] = din;
                finish       = (s_q.cnt == len);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rx_word = s_q.rx;

endmodule

// File: rtl/spi_duplex_ctrl.sv
module spi_duplex_ctrl
    import spi_duplex_pkg::*;
#(
    parameter int CW          = 8,
    parameter int MIN_PERIOD  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          sck_out,
    output logic          mosi_out,
    input  logic          miso_in,
    input  logic          sck_in,
    input  logic          mosi_in,
    output logic          miso_out,
    input  logic          ss_n_in
);

    typedef struct packed {
        ctrl_t         ctrl;
        logic [CW-1:0] rate;
        logic          done;
        logic          wcol;
        logic          armed;
        logic          run;
        logic          sck;
        logic          sck_prev;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [2:0]    sync_q;
    logic          ss_s, sck_s, mosi_s;
    logic [LW-1:0] len;
    logic          wr_data, data_acc, busy, start, collide;
    logic          tick, lead, trail, din, clr, dout, finish;
    logic [DW-1:0] rx_word;

    spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ss_n_in, sck_in, mosi_in}), .q(sync_q)
    );
    assign {ss_s, sck_s, mosi_s} = sync_q;

    spi_sck_divider #(.CW(CW), .MINP(MIN_PERIOD)) u_div (
        .clk(clk), .rst_n(rst_n), .run(st_q.run && st_q.ctrl.master),
        .period(st_q.rate), .tick(tick)
    );

    always_comb begin
        len      = width_of(st_q.ctrl);
        wr_data  = reg_wr && (reg_sel == SEL_DATA);
        data_acc = (reg_wr || reg_rd) && (reg_sel == SEL_DATA);
        busy     = st_q.ctrl.master ? st_q.run : !ss_s;
        start    = wr_data && !busy;
        collide  = wr_data && busy;
        clr      = !st_q.ctrl.master && ss_s;
        if (st_q.ctrl.master) begin
            lead  = tick && (st_q.sck == st_q.ctrl.cpol);
            trail = tick && (st_q.sck != st_q.ctrl.cpol);
            din   = miso_in;
        end else begin
            lead  = !ss_s && (sck_s != st_q.sck_prev) && (st_q.sck_prev == st_q.ctrl.cpol);
            trail = !ss_s && (sck_s != st_q.sck_prev) && (st_q.sck_prev != st_q.ctrl.cpol);
            din   = mosi_s;
        end
    end

    spi_bit_engine u_eng (
        .clk(clk), .rst_n(rst_n), .load(start), .load_word(reg_wdata), .clr(clr),
        .lead(lead), .trail(trail), .din(din), .len(len),
        .cpha(st_q.ctrl.cpha), .lsbf(st_q.ctrl.lsb_first),
        .dout(dout), .finish(finish), .rx_word(rx_word)
    );

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = sck_s;
        if (reg_wr && reg_sel == SEL_CTRL) st_d.ctrl = ctrl_t'({reg_wdata[11:8], reg_wdata[7:2]});
        if (reg_wr && reg_sel == SEL_RATE) st_d.rate = reg_wdata[CW-1:0];
        if (start && st_q.ctrl.master) begin
            st_d.run = 1'b1;
            st_d.sck = st_q.ctrl.cpol;
        end
        if (st_q.ctrl.master && tick) st_d.sck = !st_q.sck;
        if (finish && st_q.ctrl.master) st_d.run = 1'b0;
        if (reg_rd && reg_sel == SEL_STAT) st_d.armed = st_q.done || st_q.wcol;
        if (data_acc && st_q.armed) begin
            st_d.done  = 1'b0;
            st_d.wcol  = 1'b0;
            st_d.armed = 1'b0;
        end
        if (collide) st_d.wcol = 1'b1;
        if (finish)  st_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.rate <= CW'(MIN_PERIOD);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_CTRL: reg_rdata = DW'({st_q.ctrl.width_code, st_q.ctrl.irq_en, st_q.ctrl.lsb_first,
                                       st_q.ctrl.master, st_q.ctrl.cpol, st_q.ctrl.cpha,
                                       st_q.ctrl.width_en, 2'b00});
            SEL_STAT: reg_rdata = DW'({st_q.wcol, st_q.done});
            SEL_DATA: reg_rdata = rx_word;
            default:  reg_rdata = DW'(st_q.rate);
        endcase
    end

    assign sck_out  = st_q.run ? st_q.sck : st_q.ctrl.cpol;
    assign mosi_out = dout;
    assign miso_out = dout;
    assign irq      = st_q.ctrl.irq_en && (st_q.done || st_q.wcol);

endmodule

// File: rtl/spi_duplex_ctrl_chk.sv
module spi_duplex_ctrl_chk
    import spi_duplex_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          master,
    input logic          run,
    input logic          sck,
    input logic          data_wr,
    input logic          wcol,
    input logic          done,
    input logic          ss_idle,
    input logic [LW-1:0] cnt,
    input logic [LW-1:0] len,
    input logic [DW-1:0] tx
);

    // R8: a write during a transfer raises the collision flag
    p_collision_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && (master ? run : !ss_idle)) |=> wcol);

    // R8: the word being shifted is not replaced by that write
    p_word_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && (master ? run : !ss_idle)) |=> $stable(tx));

    // R7: SCK never toggles on two adjacent cycles
    p_half_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (master && run && !$stable(sck)) |=> $stable(sck));

    // R2: the bit count never passes the decoded length during a transfer
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (master && run) |-> (cnt <= len));

    // R9: completion and the end of the master transfer coincide
    p_done_ends_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (master && $rose(done)) |-> !run);

    // R11: a deselected slave holds its bit count at zero
    p_slave_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!master && ss_idle) |=> (cnt == '0));

endmodule

bind spi_duplex_ctrl spi_duplex_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .master(st_q.ctrl.master), .run(st_q.run),
    .sck(st_q.sck), .data_wr(wr_data), .wcol(st_q.wcol), .done(st_q.done),
    .ss_idle(ss_s), .cnt(u_eng.s_q.cnt), .len(len), .tx(u_eng.s_q.tx)
);

// File: tb/sim_spi_duplex_ctrl.sv
module sim_spi_duplex_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 0;
    logic rst_n = 0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [1:0]  m_sel = 0, s_sel = 0;
    logic        m_wr = 0, m_rd = 0, s_wr = 0, s_rd = 0;
    logic [15:0] m_wdata = 0, s_wdata = 0, m_rdata, s_rdata;
    logic        m_irq, s_irq, m_sck, m_mosi, m_miso_nc, s_sck_nc, s_mosi_nc, s_miso;
    logic        ss_n = 1, tb_drive = 0, tb_sck = 0;
    logic        s_sck_line;
    assign s_sck_line = tb_drive ? tb_sck : m_sck;

    spi_duplex_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(m_sel), .reg_wr(m_wr), .reg_rd(m_rd),
        .reg_wdata(m_wdata), .reg_rdata(m_rdata), .irq(m_irq), .sck_out(m_sck),
        .mosi_out(m_mosi), .miso_in(s_miso), .sck_in(1'b0), .mosi_in(1'b0),
        .miso_out(m_miso_nc), .ss_n_in(1'b1)
    );

    spi_duplex_ctrl u1 (
        .clk(clk), .rst_n(rst_n), .reg_sel(s_sel), .reg_wr(s_wr), .reg_rd(s_rd),
        .reg_wdata(s_wdata), .reg_rdata(s_rdata), .irq(s_irq), .sck_out(s_sck_nc),
        .mosi_out(s_mosi_nc), .miso_in(1'b0), .sck_in(s_sck_line), .mosi_in(m_mosi),
        .miso_out(s_miso), .ss_n_in(ss_n)
    );

    int checks = 0, errors = 0, cyc = 0;

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
            finish_run();
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input bit side, input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        if (side) begin s_sel = sel; s_wdata = d; s_wr = 1; end
        else      begin m_sel = sel; m_wdata = d; m_wr = 1; end
        @(negedge clk);
        m_wr = 0; s_wr = 0;
    endtask

    task automatic bus_rd(input bit side, input logic [1:0] sel, output logic [15:0] d);
        @(negedge clk);
        if (side) begin s_sel = sel; s_rd = 1; end
        else      begin m_sel = sel; m_rd = 1; end
        #1 d = side ? s_rdata : m_rdata;
        @(negedge clk);
        m_rd = 0; s_rd = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // wire recorder: bench-side definition of the sampling edge
    logic        rec_on = 0, sck_seen = 0, cfg_cpol = 0, cfg_cpha = 0;
    int          nbits = 0, edges = 0, gap = 0, glen = 0, gmin = 0, gmax = 0;
    logic [15:0] w_m = 0, w_s = 0;
    logic        is_lead;

    always @(negedge clk) begin
        if (rec_on) begin
            if (m_sck !== sck_seen) begin
                glen = gap + 1;
                if (edges > 0) begin
                    if (glen < gmin) gmin = glen;
                    if (glen > gmax) gmax = glen;
                end
                is_lead = (sck_seen == cfg_cpol);
                if (cfg_cpha ? !is_lead : is_lead) begin
                    if (nbits < 16) begin w_m[nbits] = m_mosi; w_s[nbits] = s_miso; end
                    nbits++;
                end
                edges++;
                gap = 0;
                sck_seen = m_sck;
            end else begin
                gap++;
            end
        end
    end

    function automatic logic [15:0] lmask(input int L);
        return (L >= 16) ? 16'hFFFF : 16'((32'd1 << L) - 1);
    endfunction

    function automatic logic [15:0] wire_order(input logic [15:0] w, input int L, input bit lsbf);
        logic [15:0] r = 0;
        for (int k = 0; k < L; k++) r[k] = lsbf ? w[k] : w[L-1-k];
        return r;
    endfunction

    task automatic wait_done(input bit side, output logic [15:0] st);
        st = 0;
        for (int t = 0; t < 500 && !st[0]; t++) bus_rd(side, 2'd1, st);
    endtask

    // one master/slave exchange with all wire-level checks
    task automatic xfer(input logic [15:0] ctl, input int L, input logic [15:0] a,
                        input logic [15:0] b, input logic [7:0] rate, input int h);
        logic [15:0] v;
        bus_wr(0, 2'd3, {8'd0, rate});
        bus_wr(0, 2'd0, ctl | 16'h0020);
        bus_wr(1, 2'd0, ctl & ~16'h0020);
        bus_wr(1, 2'd2, b);
        ss_n = 0;
        idle(4);
        chk("R3", "idle sck before transfer", m_sck, ctl[4]);
        cfg_cpol = ctl[4]; cfg_cpha = ctl[3];
        nbits = 0; edges = 0; gap = 0; gmin = 1000; gmax = 0; w_m = 0; w_s = 0;
        sck_seen = m_sck; rec_on = 1;
        bus_wr(0, 2'd2, a);
        wait_done(0, v);
        chk("R9", "master done flag", v[0], 1'b1);
        chk("R10", "irq vs enable", m_irq, ctl[7]);
        idle(8);
        rec_on = 0;
        ss_n = 1;
        chk("R3", "idle sck after transfer", m_sck, ctl[4]);
        chk("R2", "bits on wire", nbits, L);
        chk("R5", "master word order on wire", w_m, wire_order(a, L, ctl[6]));
        chk("R4", "slave word at sampling edges", w_s, wire_order(b, L, ctl[6]));
        chk("R7", "shortest half period", gmin, h);
        chk("R7", "longest half period", gmax, h);
        bus_rd(0, 2'd2, v);
        chk("R6", "master received word", v, b & lmask(L));
        bus_rd(0, 2'd1, v);
        chk("R9", "master flags cleared", v, 16'h0);
        idle(3);
        bus_rd(1, 2'd1, v);
        chk("R9", "slave done flag", v[0], 1'b1);
        bus_rd(1, 2'd2, v);
        chk("R6", "slave received word", v, a & lmask(L));
    endtask

    initial begin
        logic [15:0] v;
        int L, code, idx;
        logic [15:0] ctl, a, b;
        idle(3);
        rst_n = 1;
        idle(2);

        // R1 reset state
        bus_rd(0, 2'd0, v); chk("R1", "control reset", v, 16'h0);
        bus_rd(0, 2'd3, v); chk("R1", "clock count reset", v, 16'd8);
        bus_rd(0, 2'd1, v); chk("R1", "status reset", v, 16'h0);
        chk("R1", "irq reset", m_irq, 1'b0);
        chk("R1", "sck reset", m_sck, 1'b0);

        // sweep: idle level x phase x order x every length
        for (int m = 0; m < 8; m++) begin
            for (int w = 0; w < 10; w++) begin
                idx  = m * 10 + w;
                code = (w == 0) ? 0 : ((w == 9) ? 0 : w + 7);
                L    = (w == 0) ? 8 : ((w == 9) ? 16 : w + 7);
                ctl  = 16'(code << 8) | (w != 0 ? 16'h0004 : 16'h0)
                     | (m[0] ? 16'h0010 : 16'h0) | (m[1] ? 16'h0008 : 16'h0)
                     | (m[2] ? 16'h0040 : 16'h0);
                a = 16'hA5C3 ^ 16'(idx * 16'h1F37);
                b = 16'h3C96 + 16'(idx * 16'h0B1D);
                xfer(ctl, L, a, b, 8'd8, 4);
            end
        end

        // R2 codes 1..7 fall back to 8 bits
        xfer(16'h0304, 8, 16'hF00D, 16'h1234, 8'd8, 4);

        // R7 clock count clamp and rounding
        xfer(16'h0000, 8, 16'h00C5, 16'h0037, 8'd5, 4);
        xfer(16'h0000, 8, 16'h0081, 16'h007E, 8'd9, 4);
        xfer(16'h0018, 8, 16'h0066, 16'h0099, 8'd10, 5);
        xfer(16'h0000, 8, 16'h00E1, 16'h001E, 8'd12, 6);
        xfer(16'h0008, 8, 16'h0042, 16'h00BD, 8'd13, 6);

        // R8 collision during a master transfer, R10 irq from collision
        bus_wr(0, 2'd3, 16'd8);
        bus_wr(0, 2'd0, 16'h00A0);
        bus_wr(1, 2'd0, 16'h0000);
        bus_wr(1, 2'd2, 16'h003C);
        ss_n = 0; idle(4);
        cfg_cpol = 0; cfg_cpha = 0; nbits = 0; edges = 0; gap = 0; gmin = 1000; gmax = 0;
        w_m = 0; w_s = 0; sck_seen = m_sck; rec_on = 1;
        bus_wr(0, 2'd2, 16'h00B4);
        idle(12);
        bus_wr(0, 2'd2, 16'h005A);
        chk("R10", "irq on collision", m_irq, 1'b1);
        wait_done(0, v);
        chk("R8", "collision flag", v[1], 1'b1);
        idle(8); rec_on = 0; ss_n = 1;
        chk("R8", "wire word unchanged", w_m, wire_order(16'h00B4, 8, 0));
        bus_rd(0, 2'd2, v);
        chk("R8", "received word intact", v, 16'h003C);
        bus_rd(0, 2'd1, v);
        chk("R9", "both flags cleared", v, 16'h0);
        chk("R10", "irq low after clear", m_irq, 1'b0);
        bus_rd(1, 2'd1, v); bus_rd(1, 2'd2, v);
        chk("R6", "slave word after collision", v, 16'h00B4);

        // R9 data read without prior status read keeps flags
        bus_wr(1, 2'd2, 16'h0011);
        ss_n = 0; idle(4);
        bus_wr(0, 2'd2, 16'h0022);
        for (int t = 0; t < 500 && !m_irq; t++) @(negedge clk);
        chk("R10", "irq on completion", m_irq, 1'b1);
        bus_rd(0, 2'd2, v);
        chk("R6", "received word", v, 16'h0011);
        bus_rd(0, 2'd1, v);
        chk("R9", "done kept without status read", v, 16'h0001);
        bus_rd(0, 2'd2, v);
        bus_rd(0, 2'd1, v);
        chk("R9", "done cleared after status then data", v, 16'h0);
        idle(8); ss_n = 1;
        bus_rd(1, 2'd1, v); bus_rd(1, 2'd2, v);

        // R11 deselected slave ignores SCK
        bus_wr(1, 2'd0, 16'h0000);
        bus_wr(1, 2'd2, 16'h00C3);
        tb_drive = 1;
        for (int k = 0; k < 40; k++) begin tb_sck = ~tb_sck; idle(5); end
        tb_sck = 0; idle(5); tb_drive = 0; idle(3);
        bus_rd(1, 2'd1, v);
        chk("R11", "no completion while deselected", v, 16'h0);
        xfer(16'h0000, 8, 16'h0096, 16'h00C3, 8'd8, 4);

        finish_run();
    end

endmodule